// File: doc/BRIEF.md
# NAND Status Register Read Path

This block is the device-side logic of a parallel NAND flash die that builds an 8-bit status word and places it on the data bus when the host asks for it. It watches the command bytes the die has latched. When the status opcode arrives, the die enters status-read mode. Any other opcode returns it to array-read mode, in which the bus carries the array data supplied by the page logic.

The status word is built from live signals: the write-protect pin, the busy flag of the program/erase/read controller, and an error flag that records the result of the last program or erase. Because these bits are live, a host that holds Chip Enable and Read Enable low sees the word change without pulsing either strobe. The bus is driven only while this die's own Chip Enable and Read Enable are both low. Several dies can therefore share a Ready/Busy line, and the host can still poll each one on its own.

Top module: `nand_status_read`

## Requirements
- R1: In status-read mode, bit 7 of the driven word equals the write-protect pin `wp_n`: 1 means unprotected, 0 means protected.
- R2: In status-read mode, bit 6 is 0 while `ctrl_busy` is high and 1 while it is low.
- R3: In status-read mode, bit 0 is the error flag. When `ctrl_busy` falls while a program or erase is pending, the flag takes the value of `op_fail` sampled in the same cycle, and it is visible from the following cycle.
- R4: A `pe_start` pulse clears the error flag from the next cycle on. If it coincides with a busy fall, the clear takes priority.
- R5: A busy fall that has no pending program or erase leaves the error flag unchanged.
- R6: In status-read mode, bits 5 down to 1 are driven as 0.
- R7: `io_oe` is 1 exactly when `ce_n` and `re_n` are both low. Data therefore appears in the cycle in which the later of the two strobes falls. While `io_oe` is 0, `io_out` is 0.
- R8: A latched command byte of 0x70 puts the block in status-read mode from the next cycle, and the mode persists through any number of cycles with no new command.
- R9: A latched command byte other than 0x70 selects array-read mode from the next cycle. In that mode an enabled bus carries `array_data` unchanged.
- R10: While both strobes stay low, the driven status word follows changes on `wp_n` and `ctrl_busy` in the same cycle.
- R11: After reset the block is in array-read mode with the error flag at 0 and no program or erase pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle pulse: a command byte has been latched |
| cmd_byte | input | 8 | Latched command byte |
| ce_n | input | 1 | Chip Enable, active low |
| re_n | input | 1 | Read Enable, active low |
| wp_n | input | 1 | Write-protect pin, low means protected |
| ctrl_busy | input | 1 | Controller busy flag |
| pe_start | input | 1 | Pulse: a program or erase has started |
| op_fail | input | 1 | Controller pass (0) / fail (1) result |
| array_data | input | 8 | Array byte used in array-read mode |
| io_out | output | 8 | Data driven onto the I/O bus |
| io_oe | output | 1 | Output enable for the I/O bus |

## Verification
The bench builds the block with its default parameters: 8-bit word, opcode 0x70, bit positions 7/6/0, reserved fill 0, and the unregistered output variant. With the unregistered variant, the strobe-to-data timing of R7 and the live-update behaviour of R10 can be observed in the very cycle the inputs change. Directed phases cover a status command issued in the middle of an array read, a failed erase followed by a read-only busy period, and a new program that clears the flag while busy falls in the same cycle. A long stretch of random strobes, commands and controller activity then runs against the reference model.

// File: rtl/nand_sr_pkg.sv
package nand_sr_pkg;
   typedef enum logic {
      MODE_ARRAY  = 1'b0,
      MODE_STATUS = 1'b1
   } rd_mode_e;
endpackage

// File: rtl/nsr_mode_track.sv
module nsr_mode_track
   import nand_sr_pkg::*;
#(
   parameter int          CMD_W     = 8,
   parameter logic [7:0]  STATUS_OP = 8'h70
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [CMD_W-1:0] cmd_byte,
   output rd_mode_e         mode
);
   localparam logic [CMD_W-1:0] OPC = CMD_W'(STATUS_OP);

   always_ff @(posedge clk) begin
      if (!rst_n)
         mode <= MODE_ARRAY;
      else if (cmd_valid)
         mode <= (cmd_byte == OPC) ? MODE_STATUS : MODE_ARRAY;
   end
endmodule

// File: rtl/nsr_err_track.sv
module nsr_err_track (
   input  logic clk,
   input  logic rst_n,
   input  logic ctrl_busy,
   input  logic pe_start,
   input  logic op_fail,
   output logic err_flag,
   output logic pe_pend
);
   logic busy_q;
   logic busy_fall;

   assign busy_fall = busy_q & ~ctrl_busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         err_flag <= 1'b0;
         pe_pend  <= 1'b0;
      end else begin
         busy_q <= ctrl_busy;
         if (pe_start) begin
            err_flag <= 1'b0;
            pe_pend  <= 1'b1;
         end else if (busy_fall && pe_pend) begin
            err_flag <= op_fail;
            pe_pend  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/nsr_bus_drive.sv
module nsr_bus_drive
   import nand_sr_pkg::*;
#(
   parameter int   DATA_W   = 8,
   parameter int   WP_BIT   = 7,
   parameter int   RDY_BIT  = 6,
   parameter int   ERR_BIT  = 0,
   parameter logic RESV_VAL = 1'b0,
   parameter bit   OUT_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  rd_mode_e          mode,
   input  logic              ce_n,
   input  logic              re_n,
   input  logic              wp_n,
   input  logic              ctrl_busy,
   input  logic              err_flag,
   input  logic [DATA_W-1:0] array_data,
   output logic [DATA_W-1:0] io_out,
   output logic              io_oe
);
   logic [DATA_W-1:0] status_word;
   logic [DATA_W-1:0] sel_word;
   logic              sel_oe;

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      if (b == WP_BIT) begin : g_wp
         assign status_word[b] = wp_n;
      end else if (b == RDY_BIT) begin : g_rdy
         assign status_word[b] = ~ctrl_busy;
      end else if (b == ERR_BIT) begin : g_err
         assign status_word[b] = err_flag;
      end else begin : g_resv
         assign status_word[b] = RESV_VAL;
      end
   end

   assign sel_oe   = ~ce_n & ~re_n;
   assign sel_word = !sel_oe ? '0 :
                     (mode == MODE_STATUS) ? status_word : array_data;

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            io_out <= '0;
            io_oe  <= 1'b0;
         end else begin
            io_out <= sel_word;
            io_oe  <= sel_oe;
         end
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign io_out = sel_word;
      assign io_oe  = sel_oe;
   end
endmodule

// File: rtl/nand_status_read.sv
module nand_status_read
   import nand_sr_pkg::*;
#(
   parameter int          DATA_W    = 8,
   parameter int          CMD_W     = 8,
   parameter logic [7:0]  STATUS_OP = 8'h70,
   parameter int          WP_BIT    = 7,
   parameter int          RDY_BIT   = 6,
   parameter int          ERR_BIT   = 0,
   parameter logic        RESV_VAL  = 1'b0,
   parameter bit          OUT_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [CMD_W-1:0]  cmd_byte,
   input  logic              ce_n,
   input  logic              re_n,
   input  logic              wp_n,
   input  logic              ctrl_busy,
   input  logic              pe_start,
   input  logic              op_fail,
   input  logic [DATA_W-1:0] array_data,
   output logic [DATA_W-1:0] io_out,
   output logic              io_oe
);
   localparam int MAX_BIT = DATA_W - 1;

   if (DATA_W < 3 || CMD_W < 8) begin : g_chk_w
      $error("nand_status_read: DATA_W must be >= 3 and CMD_W >= 8");
   end
   if (WP_BIT > MAX_BIT || RDY_BIT > MAX_BIT || ERR_BIT > MAX_BIT ||
       WP_BIT < 0 || RDY_BIT < 0 || ERR_BIT < 0) begin : g_chk_range
      $error("nand_status_read: status bit position out of range");
   end
   if (WP_BIT == RDY_BIT || WP_BIT == ERR_BIT || RDY_BIT == ERR_BIT) begin : g_chk_dist
      $error("nand_status_read: status bit positions must differ");
   end

   rd_mode_e mode;
   logic     err_flag;
   logic     pe_pend;
   logic     status_mode;

   assign status_mode = (mode == MODE_STATUS);

   nsr_mode_track #(
      .CMD_W     (CMD_W),
      .STATUS_OP (STATUS_OP)
   ) u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_byte  (cmd_byte),
      .mode      (mode)
   );

   nsr_err_track u_err (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_busy (ctrl_busy),
      .pe_start  (pe_start),
      .op_fail   (op_fail),
      .err_flag  (err_flag),
      .pe_pend   (pe_pend)
   );

   nsr_bus_drive #(
      .DATA_W   (DATA_W),
      .WP_BIT   (WP_BIT),
      .RDY_BIT  (RDY_BIT),
      .ERR_BIT  (ERR_BIT),
      .RESV_VAL (RESV_VAL),
      .OUT_REG  (OUT_REG)
   ) u_bus (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (mode),
      .ce_n       (ce_n),
      .re_n       (re_n),
      .wp_n       (wp_n),
      .ctrl_busy  (ctrl_busy),
      .err_flag   (err_flag),
      .array_data (array_data),
      .io_out     (io_out),
      .io_oe      (io_oe)
   );
endmodule

// File: rtl/nand_status_read_chk.sv
module nand_status_read_chk #(
   parameter int          DATA_W    = 8,
   parameter int          CMD_W     = 8,
   parameter logic [7:0]  STATUS_OP = 8'h70,
   parameter int          WP_BIT    = 7,
   parameter int          RDY_BIT   = 6,
   parameter int          ERR_BIT   = 0,
   parameter bit          OUT_REG   = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic [CMD_W-1:0]  cmd_byte,
   input logic              ce_n,
   input logic              re_n,
   input logic              wp_n,
   input logic              ctrl_busy,
   input logic              pe_start,
   input logic              op_fail,
   input logic [DATA_W-1:0] io_out,
   input logic              io_oe,
   input logic              status_mode,
   input logic              err_flag,
   input logic              pe_pend
);
   localparam logic [CMD_W-1:0] OPC = CMD_W'(STATUS_OP);

   assert_status_enter_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_byte == OPC) |=> status_mode);

   assert_array_enter_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_byte != OPC) |=> !status_mode);

   assert_err_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pe_start |=> !err_flag);

   assert_err_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ctrl_busy) && pe_pend && !pe_start) |=> (err_flag == $past(op_fail)));

   assert_err_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!pe_pend && !pe_start) |=> $stable(err_flag));

   if (!OUT_REG) begin : g_comb_props
      assert_oe_strobes_R7: assert property (@(posedge clk) disable iff (!rst_n)
         io_oe == (!ce_n && !re_n));

      assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
         !io_oe |-> (io_out == '0));

      assert_wp_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
         (io_oe && status_mode) |-> (io_out[WP_BIT] == wp_n));

      assert_rdy_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (io_oe && status_mode) |-> (io_out[RDY_BIT] == !ctrl_busy));

      assert_err_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (io_oe && status_mode) |-> (io_out[ERR_BIT] == err_flag));

      assert_resv_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (io_oe && status_mode) |->
            ($countones(io_out) == (32'(io_out[WP_BIT]) + 32'(io_out[RDY_BIT]) + 32'(io_out[ERR_BIT]))));
   end
endmodule

bind nand_status_read nand_status_read_chk #(
   .DATA_W    (DATA_W),
   .CMD_W     (CMD_W),
   .STATUS_OP (STATUS_OP),
   .WP_BIT    (WP_BIT),
   .RDY_BIT   (RDY_BIT),
   .ERR_BIT   (ERR_BIT),
   .OUT_REG   (OUT_REG)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_valid   (cmd_valid),
   .cmd_byte    (cmd_byte),
   .ce_n        (ce_n),
   .re_n        (re_n),
   .wp_n        (wp_n),
   .ctrl_busy   (ctrl_busy),
   .pe_start    (pe_start),
   .op_fail     (op_fail),
   .io_out      (io_out),
   .io_oe       (io_oe),
   .status_mode (status_mode),
   .err_flag    (err_flag),
   .pe_pend     (pe_pend)
);

// File: tb/nand_status_read_test.sv
`timescale 1ns/1ps
module nand_status_read_test;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       cmd_valid;
   logic [7:0] cmd_byte;
   logic       ce_n, re_n, wp_n, ctrl_busy, pe_start, op_fail;
   logic [7:0] array_data;
   logic [7:0] io_out;
   logic       io_oe;

   int n_cmp  = 0;
   int n_fail = 0;
   int cycles = 0;

   // reference model state
   bit m_status;
   bit m_err;
   bit m_pend;
   bit m_busy_prev;

   always #2.5 clk = ~clk;

   nand_status_read uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
      .ce_n(ce_n), .re_n(re_n), .wp_n(wp_n), .ctrl_busy(ctrl_busy),
      .pe_start(pe_start), .op_fail(op_fail), .array_data(array_data),
      .io_out(io_out), .io_oe(io_oe)
   );

   task automatic report(string phase, string req, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL [%s] %s: actual 0x%0h expected 0x%0h", phase, req, act, exp);
      end
   endtask

   // compare outputs against the model, then advance the model one clock
   task automatic step(string phase);
      bit       e_oe;
      bit [7:0] e_word;
      #1;
      e_oe = !ce_n && !re_n;
      report(phase, "R7 oe", int'(io_oe), int'(e_oe));
      if (!e_oe) begin
         report(phase, "R7 idle data", int'(io_out), 0);
      end else if (m_status) begin
         report(phase, "R1 wp bit", int'(io_out[7]), int'(wp_n));
         report(phase, "R2 ready bit", int'(io_out[6]), int'(!ctrl_busy));
         report(phase, "R6 reserved", int'(io_out[5:1]), 0);
         report(phase, "R3 error bit", int'(io_out[0]), int'(m_err));
      end else begin
         report(phase, "R9 array data", int'(io_out), int'(array_data));
      end
      if (!rst_n) begin
         m_status = 0; m_err = 0; m_pend = 0; m_busy_prev = 0;
      end else begin
         if (cmd_valid) m_status = (cmd_byte == 8'h70);
         if (pe_start) begin
            m_err = 0; m_pend = 1;
         end else if (m_busy_prev && !ctrl_busy && m_pend) begin
            m_err = op_fail; m_pend = 0;
         end
         m_busy_prev = ctrl_busy;
      end
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 0;
      pe_start  = 0;
   endtask

   task automatic issue(logic [7:0] c, string phase);
      cmd_valid = 1; cmd_byte = c;
      step(phase);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         n_fail++;
         $display("FAIL watchdog (all requirements): actual hung expected finish");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 0; cmd_valid = 0; cmd_byte = 8'h00; ce_n = 1; re_n = 1;
      wp_n = 1; ctrl_busy = 0; pe_start = 0; op_fail = 0; array_data = 8'hA5;
      @(negedge clk);
      repeat (3) step("reset");
      rst_n = 1;
      // R11: array mode after reset, strobes low show array data
      ce_n = 0; re_n = 0;
      step("R11 reset state");
      ce_n = 1; re_n = 1;
      step("R11 idle");

      // R8: status command, mode persists
      issue(8'h70, "R8 enter");
      ce_n = 0; step("R7 ce only");
      re_n = 0; step("R7 later strobe");
      repeat (4) step("R8 persist");
      // R10: live update with strobes held low
      wp_n = 0; step("R10 wp low");
      ctrl_busy = 1; step("R10 busy");
      wp_n = 1; ctrl_busy = 0; step("R10 ready");

      // R3: failed erase sets the flag
      pe_start = 1; ctrl_busy = 1; step("R3 start");
      repeat (3) step("R3 busy");
      ctrl_busy = 0; op_fail = 1; step("R3 fall");
      op_fail = 0; step("R3 visible");
      // R5: read-only busy period keeps the flag
      ctrl_busy = 1; repeat (2) step("R5 busy");
      ctrl_busy = 0; step("R5 fall");
      step("R5 hold");
      // R4: new program clears; coincident fall gives clear priority
      ctrl_busy = 1; step("R4 busy");
      ctrl_busy = 0; pe_start = 1; op_fail = 1; step("R4 clear with fall");
      op_fail = 0; step("R4 cleared");
      ctrl_busy = 1; step("R4 busy2");
      ctrl_busy = 0; step("R4 pass");
      step("R4 pass visible");

      // R9: status command during array read, then new read command
      issue(8'h00, "R9 array");
      array_data = 8'h3C; step("R9 data");
      issue(8'h70, "R8 mid read");
      array_data = 8'hC3; step("R8 status in read");
      step("R8 status in read 2");
      issue(8'h05, "R9 back");
      step("R9 array again");
      re_n = 1; step("R7 re up");
      ce_n = 1; re_n = 0; step("R7 ce up");

      // random stretch
      for (int i = 0; i < 3000; i++) begin
         ce_n       = ($urandom % 4) == 0;
         re_n       = ($urandom % 4) == 0;
         wp_n       = $urandom % 2;
         ctrl_busy  = ($urandom % 3) != 0 ? ctrl_busy : !ctrl_busy;
         pe_start   = ($urandom % 16) == 0;
         op_fail    = $urandom % 2;
         array_data = 8'($urandom);
         cmd_valid  = ($urandom % 8) == 0;
         cmd_byte   = ($urandom % 2) ? 8'h70 : 8'($urandom);
         step("random");
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
   end
endmodule